// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block handles precise exceptions for a five-stage in-order pipeline. Two stages can raise an instruction-caused exception. Decode raises one for an opcode it does not recognise. Execute raises one for a signed arithmetic overflow. An external interrupt request can also arrive at any cycle. In the cycle an event is seen, the controller chooses one winner. It then squashes the stages that hold instructions younger than the point of the exception and steers fetch to a fixed handler address. On the next clock edge it records the address of the instruction to resume at, together with a cause code.

The squash actions are combinational and apply in the same cycle as the event. Decode is squashed by replacing its instruction word with all zeroes, which is a no-op. Execute is squashed by clearing its control bundle, so the instruction writes no register and no memory. Fetch is squashed by discarding its word, and the surrounding pipeline acts on `flush_if`.

An interrupt belongs to no instruction. In the default variant, the instruction already in execute is allowed to finish, and the resume address is the oldest instruction still behind it. A parameter selects the other variant, in which execute is also drained on an interrupt.

Top module: `exc_flush_ctrl`

## Requirements
- R1: After reset, `epc` is 0 and `cause` is 0. With no event present, `flush_if`, `flush_id`, `flush_ex` and `redirect` are all 0.
- R2: When `ex_valid` and `ex_ovf` are both 1, `flush_if`, `flush_id`, `flush_ex` and `redirect` are all 1 in the same cycle, and `next_pc` equals the handler address (default 0x40000040).
- R3: On an execute overflow, `ex_ctrl_out` is all zeroes in the same cycle. After the next clock edge, `epc` holds that cycle's `ex_pc` and `cause` is 2.
- R4: When `id_valid` and `id_illegal` are both 1 and there is no execute overflow, `flush_if` and `flush_id` are 1 and `flush_ex` is 0. `id_instr_out` is all zeroes and `ex_ctrl_out` equals `ex_ctrl`. After the next edge, `epc` holds `id_pc` and `cause` is 1.
- R5: When an execute overflow and a decode illegal instruction occur in the same cycle, the overflow wins: after the edge, `epc` is `ex_pc` and `cause` is 2.
- R6: An interrupt (`irq_req`=1) with no instruction exception present raises `redirect`, `flush_if` and `flush_id`. In the default variant `flush_ex` stays 0 and `ex_ctrl_out` passes through. After the edge, `cause` is 0 and `epc` is `id_pc` if `id_valid` is 1, otherwise `if_pc`.
- R7: An interrupt that arrives in the same cycle as an instruction exception is not taken: the instruction exception alone sets `epc` and `cause`.
- R8: With no event present, `next_pc` equals `seq_pc`, the instruction and control buses pass through unchanged, and `epc` and `cause` keep their values across the edge.
- R9: An exception flag raised while its stage's valid bit is 0 has no effect: no flush, no redirect, and `epc`/`cause` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_pc | input | AW | PC of the instruction in fetch |
| seq_pc | input | AW | Sequential next fetch address |
| id_valid | input | 1 | Decode holds a real instruction |
| id_pc | input | AW | PC of the instruction in decode |
| id_instr | input | IW | Instruction word in decode |
| id_illegal | input | 1 | Decode found an unknown opcode |
| ex_valid | input | 1 | Execute holds a real instruction |
| ex_pc | input | AW | PC of the instruction in execute |
| ex_ctrl | input | CTW | Control bundle of the instruction in execute |
| ex_ovf | input | 1 | Execute produced an arithmetic overflow |
| irq_req | input | 1 | External interrupt request |
| next_pc | output | AW | Fetch address: handler on redirect, else `seq_pc` |
| redirect | output | 1 | An exception is taken this cycle |
| flush_if | output | 1 | Discard the fetched word |
| flush_id | output | 1 | Decode squashed |
| flush_ex | output | 1 | Execute squashed |
| id_instr_out | output | IW | Decode word after squash (zero when squashed) |
| ex_ctrl_out | output | CTW | Execute controls after squash (zero when squashed) |
| epc | output | AW | Saved resume address |
| cause | output | CAUSE_W | Saved cause: 0 interrupt, 1 illegal, 2 overflow |

## Verification
The bench targets the simultaneous cases. When an overflow and an illegal opcode coincide, a wrong priority would save the younger decode PC with cause 1. When an interrupt coincides with an illegal opcode, a design that lets the interrupt win would save cause 0. It also raises exception flags on stages marked invalid, where a careless decode would flush and overwrite `epc`. For an interrupt, the bench checks that execute is left alone. It also checks that the saved address moves to `if_pc` when decode is empty; a design that got this wrong would either kill a completing instruction or resume at a stale PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_IRQ  = 2'd1,
      SRC_ILL  = 2'd2,
      SRC_OVF  = 2'd3
   } exc_src_e;

   localparam int CAUSE_IRQ = 0;
   localparam int CAUSE_ILL = 1;
   localparam int CAUSE_OVF = 2;

   // stage index: 0 fetch, 1 decode, 2 execute
   localparam int NUM_STAGES = 3;
   localparam int STG_ID     = 1;
   localparam int STG_EX     = 2;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic     id_valid,
   input  logic     id_illegal,
   input  logic     ex_valid,
   input  logic     ex_ovf,
   input  logic     irq_req,
   output exc_src_e src
);
   logic ovf_hit;
   logic ill_hit;

   assign ovf_hit = ex_valid & ex_ovf;
   assign ill_hit = id_valid & id_illegal;

   // oldest instruction first; interrupt only on a clean cycle
   always_comb begin
      if (ovf_hit)      src = SRC_OVF;
      else if (ill_hit) src = SRC_ILL;
      else if (irq_req) src = SRC_IRQ;
      else              src = SRC_NONE;
   end
endmodule

// File: rtl/exc_squash.sv
module exc_squash
   import exc_pkg::*;
#(
   parameter int IW           = 32,
   parameter int CTW          = 8,
   parameter bit IRQ_EX_DRAIN = 1'b1
) (
   input  exc_src_e             src,
   input  logic [IW-1:0]        id_instr,
   input  logic [CTW-1:0]       ex_ctrl,
   output logic [NUM_STAGES-1:0] flush_vec,
   output logic [IW-1:0]        id_instr_out,
   output logic [CTW-1:0]       ex_ctrl_out
);
   localparam int DW = $clog2(NUM_STAGES);

   logic          active;
   logic [DW-1:0] depth;
   logic [DW-1:0] irq_depth;

   generate
      if (IRQ_EX_DRAIN) begin : g_irq_let_ex
         assign irq_depth = DW'(STG_ID);
      end else begin : g_irq_kill_ex
         assign irq_depth = DW'(STG_EX);
      end
   endgenerate

   always_comb begin
      active = (src != SRC_NONE);
      unique case (src)
         SRC_OVF: depth = DW'(STG_EX);
         SRC_ILL: depth = DW'(STG_ID);
         SRC_IRQ: depth = irq_depth;
         default: depth = '0;
      endcase
   end

   // every stage at or younger than the faulting depth is squashed
   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         assign flush_vec[s] = active && (DW'(s) <= depth);
      end
   endgenerate

   assign id_instr_out = flush_vec[STG_ID] ? '0 : id_instr;
   assign ex_ctrl_out  = flush_vec[STG_EX] ? '0 : ex_ctrl;
endmodule

// File: rtl/exc_record.sv
module exc_record
   import exc_pkg::*;
#(
   parameter int AW           = 32,
   parameter int CAUSE_W      = 4,
   parameter bit IRQ_EX_DRAIN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  exc_src_e           src,
   input  logic [AW-1:0]      if_pc,
   input  logic               id_valid,
   input  logic [AW-1:0]      id_pc,
   input  logic               ex_valid,
   input  logic [AW-1:0]      ex_pc,
   output logic [AW-1:0]      epc,
   output logic [CAUSE_W-1:0] cause
);
   logic [AW-1:0] irq_pc;
   logic [AW-1:0] behind_ex_pc;

   assign behind_ex_pc = id_valid ? id_pc : if_pc;

   // resume at the oldest instruction that will not complete
   generate
      if (IRQ_EX_DRAIN) begin : g_irq_pc_drain
         assign irq_pc = behind_ex_pc;
      end else begin : g_irq_pc_kill
         assign irq_pc = ex_valid ? ex_pc : behind_ex_pc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc   <= '0;
         cause <= '0;
      end else begin
         unique case (src)
            SRC_OVF: begin
               epc   <= ex_pc;
               cause <= CAUSE_W'(CAUSE_OVF);
            end
            SRC_ILL: begin
               epc   <= id_pc;
               cause <= CAUSE_W'(CAUSE_ILL);
            end
            SRC_IRQ: begin
               epc   <= irq_pc;
               cause <= CAUSE_W'(CAUSE_IRQ);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
   import exc_pkg::*;
#(
   parameter int            AW           = 32,
   parameter int            IW           = 32,
   parameter int            CTW          = 8,
   parameter int            CAUSE_W      = 4,
   parameter logic [AW-1:0] HANDLER_ADDR = AW'(32'h4000_0040),
   parameter bit            IRQ_EX_DRAIN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      if_pc,
   input  logic [AW-1:0]      seq_pc,
   input  logic               id_valid,
   input  logic [AW-1:0]      id_pc,
   input  logic [IW-1:0]      id_instr,
   input  logic               id_illegal,
   input  logic               ex_valid,
   input  logic [AW-1:0]      ex_pc,
   input  logic [CTW-1:0]     ex_ctrl,
   input  logic               ex_ovf,
   input  logic               irq_req,
   output logic [AW-1:0]      next_pc,
   output logic               redirect,
   output logic               flush_if,
   output logic               flush_id,
   output logic               flush_ex,
   output logic [IW-1:0]      id_instr_out,
   output logic [CTW-1:0]     ex_ctrl_out,
   output logic [AW-1:0]      epc,
   output logic [CAUSE_W-1:0] cause
);
   generate
      if (AW < 2)        begin : g_bad_aw    $error("AW too small");            end
      if (IW < 1)        begin : g_bad_iw    $error("IW must be positive");     end
      if (CTW < 1)       begin : g_bad_ctw   $error("CTW must be positive");    end
      if (CAUSE_W < 2)   begin : g_bad_cause $error("CAUSE_W must hold 0..2");  end
      if (HANDLER_ADDR[1:0] != 2'b00) begin : g_bad_handler
         $error("HANDLER_ADDR must be word aligned");
      end
   endgenerate

   exc_src_e              src;
   logic [NUM_STAGES-1:0] flush_vec;

   exc_arbiter u_arb (
      .id_valid   (id_valid),
      .id_illegal (id_illegal),
      .ex_valid   (ex_valid),
      .ex_ovf     (ex_ovf),
      .irq_req    (irq_req),
      .src        (src)
   );

   exc_squash #(.IW(IW), .CTW(CTW), .IRQ_EX_DRAIN(IRQ_EX_DRAIN)) u_squash (
      .src          (src),
      .id_instr     (id_instr),
      .ex_ctrl      (ex_ctrl),
      .flush_vec    (flush_vec),
      .id_instr_out (id_instr_out),
      .ex_ctrl_out  (ex_ctrl_out)
   );

   exc_record #(.AW(AW), .CAUSE_W(CAUSE_W), .IRQ_EX_DRAIN(IRQ_EX_DRAIN)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .if_pc    (if_pc),
      .id_valid (id_valid),
      .id_pc    (id_pc),
      .ex_valid (ex_valid),
      .ex_pc    (ex_pc),
      .epc      (epc),
      .cause    (cause)
   );

   assign flush_if = flush_vec[0];
   assign flush_id = flush_vec[STG_ID];
   assign flush_ex = flush_vec[STG_EX];
   assign redirect = (src != SRC_NONE);
   assign next_pc  = redirect ? HANDLER_ADDR : seq_pc;
endmodule

// File: rtl/exc_flush_ctrl_chk.sv
module exc_flush_ctrl_chk #(
   parameter int            AW           = 32,
   parameter int            IW           = 32,
   parameter int            CTW          = 8,
   parameter int            CAUSE_W      = 4,
   parameter logic [AW-1:0] HANDLER_ADDR = AW'(32'h4000_0040),
   parameter bit            IRQ_EX_DRAIN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AW-1:0]      if_pc,
   input logic [AW-1:0]      seq_pc,
   input logic               id_valid,
   input logic [AW-1:0]      id_pc,
   input logic [IW-1:0]      id_instr,
   input logic               id_illegal,
   input logic               ex_valid,
   input logic [AW-1:0]      ex_pc,
   input logic [CTW-1:0]     ex_ctrl,
   input logic               ex_ovf,
   input logic               irq_req,
   input logic [AW-1:0]      next_pc,
   input logic               redirect,
   input logic               flush_if,
   input logic               flush_id,
   input logic               flush_ex,
   input logic [IW-1:0]      id_instr_out,
   input logic [CTW-1:0]     ex_ctrl_out,
   input logic [AW-1:0]      epc,
   input logic [CAUSE_W-1:0] cause
);
   logic ovf_ev, ill_ev, any_ev;
   assign ovf_ev = ex_valid && ex_ovf;
   assign ill_ev = id_valid && id_illegal;
   assign any_ev = ovf_ev || ill_ev || irq_req;

   AST_OVF_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |-> (flush_if && flush_id && flush_ex && next_pc == HANDLER_ADDR)); // R2
   AST_OVF_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |-> (ex_ctrl_out == '0)); // R3
   AST_OVF_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |=> (epc == $past(ex_pc) && cause == CAUSE_W'(2))); // R5
   AST_ILL_KEEP_EX: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_ev && !ovf_ev) |-> (flush_id && flush_if && !flush_ex && id_instr_out == '0)); // R4
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !ovf_ev && !ill_ev) |=> (cause == '0)); // R6
   AST_IRQ_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && (ovf_ev || ill_ev)) |=> (cause != '0)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ev |=> ($stable(epc) && $stable(cause))); // R8
   AST_IDLE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ev |-> (!redirect && !flush_if && !flush_id && !flush_ex && next_pc == seq_pc)); // R9
endmodule

bind exc_flush_ctrl exc_flush_ctrl_chk #(
   .AW(AW), .IW(IW), .CTW(CTW), .CAUSE_W(CAUSE_W),
   .HANDLER_ADDR(HANDLER_ADDR), .IRQ_EX_DRAIN(IRQ_EX_DRAIN)
) u_chk (.*);

// File: tb/exc_flush_ctrl_bench.sv
module exc_flush_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, IW = 32, CTW = 8, CW = 4;
   localparam logic [AW-1:0] HANDLER = 32'h4000_0040;

   logic clk = 1'b0;
   logic rst_n;
   logic [AW-1:0] if_pc, seq_pc, id_pc, ex_pc;
   logic id_valid, id_illegal, ex_valid, ex_ovf, irq_req;
   logic [IW-1:0] id_instr;
   logic [CTW-1:0] ex_ctrl;
   logic [AW-1:0] next_pc, epc;
   logic redirect, flush_if, flush_id, flush_ex;
   logic [IW-1:0] id_instr_out;
   logic [CTW-1:0] ex_ctrl_out;
   logic [CW-1:0] cause;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_flush_ctrl u_exc_flush_ctrl (
      .clk(clk), .rst_n(rst_n), .if_pc(if_pc), .seq_pc(seq_pc),
      .id_valid(id_valid), .id_pc(id_pc), .id_instr(id_instr), .id_illegal(id_illegal),
      .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_ctrl(ex_ctrl), .ex_ovf(ex_ovf),
      .irq_req(irq_req), .next_pc(next_pc), .redirect(redirect),
      .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
      .id_instr_out(id_instr_out), .ex_ctrl_out(ex_ctrl_out),
      .epc(epc), .cause(cause)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, outputs settle before the next posedge
   task automatic drive(input logic iv, input logic [AW-1:0] ipc, input logic ill,
                        input logic ev, input logic [AW-1:0] xpc, input logic ovf,
                        input logic irq);
      @(negedge clk);
      id_valid = iv; id_pc = ipc; id_illegal = ill;
      ex_valid = ev; ex_pc = xpc; ex_ovf = ovf; irq_req = irq;
      #1;
   endtask

   task automatic quiet();
      @(negedge clk);
      id_illegal = 1'b0; ex_ovf = 1'b0; irq_req = 1'b0;
      #1;
   endtask

   task automatic after_edge();
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      if_pc = 32'h0000_2000; seq_pc = 32'h0000_2004;
      id_instr = 32'h0123_4567; ex_ctrl = 8'hA5;
      id_valid = 0; id_pc = 0; id_illegal = 0;
      ex_valid = 0; ex_pc = 0; ex_ovf = 0; irq_req = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 epc", epc, 0);
      chk("R1 cause", cause, 0);
      chk("R1 flushes", {redirect, flush_if, flush_id, flush_ex}, 0);
   endtask

   task automatic t_idle();
      drive(1, 32'h1FFC, 0, 1, 32'h1FF8, 0, 0);
      chk("R8 next_pc", next_pc, seq_pc);
      chk("R8 id pass", id_instr_out, id_instr);
      chk("R8 ex pass", ex_ctrl_out, ex_ctrl);
      after_edge();
      chk("R8 epc hold", epc, 0);
      chk("R8 cause hold", cause, 0);
   endtask

   task automatic t_overflow();
      drive(1, 32'h1004, 0, 1, 32'h1000, 1, 0);
      chk("R2 flushes", {redirect, flush_if, flush_id, flush_ex}, 4'hF);
      chk("R2 next_pc", next_pc, HANDLER);
      chk("R3 ex_ctrl zero", ex_ctrl_out, 0);
      after_edge();
      chk("R3 epc", epc, 32'h1000);
      chk("R3 cause", cause, 2);
      quiet();
   endtask

   task automatic t_illegal();
      drive(1, 32'h3008, 1, 1, 32'h3004, 0, 0);
      chk("R4 flushes", {redirect, flush_if, flush_id, flush_ex}, 4'hE);
      chk("R4 id nop", id_instr_out, 0);
      chk("R4 ex pass", ex_ctrl_out, ex_ctrl);
      after_edge();
      chk("R4 epc", epc, 32'h3008);
      chk("R4 cause", cause, 1);
      quiet();
   endtask

   task automatic t_both();
      drive(1, 32'h5008, 1, 1, 32'h5004, 1, 0);
      chk("R5 flush_ex", flush_ex, 1);
      after_edge();
      chk("R5 epc", epc, 32'h5004);
      chk("R5 cause", cause, 2);
      quiet();
   endtask

   task automatic t_irq_id();
      drive(1, 32'h6008, 0, 1, 32'h6004, 0, 1);
      chk("R6 flushes", {redirect, flush_if, flush_id, flush_ex}, 4'hE);
      chk("R6 ex pass", ex_ctrl_out, ex_ctrl);
      chk("R6 next_pc", next_pc, HANDLER);
      after_edge();
      chk("R6 epc id", epc, 32'h6008);
      chk("R6 cause", cause, 0);
      quiet();
   endtask

   task automatic t_irq_empty_id();
      drive(1, 32'h0000_0100, 1, 0, 32'h0, 0, 0); // illegal: cause 1 first
      after_edge();
      drive(0, 32'h7008, 0, 1, 32'h7004, 0, 1);
      after_edge();
      chk("R6 epc if", epc, if_pc);
      chk("R6 cause irq", cause, 0);
      quiet();
   endtask

   task automatic t_irq_with_ill();
      drive(1, 32'h8008, 1, 1, 32'h8004, 0, 1);
      chk("R7 flush_ex", flush_ex, 0);
      after_edge();
      chk("R7 epc", epc, 32'h8008);
      chk("R7 cause", cause, 1);
      quiet();
   endtask

   task automatic t_invalid_flags();
      drive(0, 32'h9008, 1, 0, 32'h9004, 1, 0);
      chk("R9 flushes", {redirect, flush_if, flush_id, flush_ex}, 0);
      chk("R9 next_pc", next_pc, seq_pc);
      after_edge();
      chk("R9 epc", epc, 32'h8008);
      chk("R9 cause", cause, 1);
      quiet();
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_idle();
      t_overflow();
      t_illegal();
      t_both();
      t_irq_id();
      t_irq_empty_id();
      t_irq_with_ill();
      t_invalid_flags();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule